// File: doc/BRIEF.md
# Host Adapter Vendor Command Engine

This block decodes the vendor-specific part of a host adapter's command channel. The host writes a byte stream into a single write port. The first byte of each command is an opcode. The engine looks up how many parameter bytes that opcode needs, collects them, and then executes the command in one cycle. Commands act on a 256-byte configuration image, a lock flag and a small set of mailbox-setup registers.

Any reply bytes are queued behind a count. The host drains them one at a time through a read port. A single-cycle command-done flag marks each completed command. An invalid-command status bit marks opcodes the engine does not know, and also new opcodes written while the engine cannot take them. Configuration reads do not copy data: they stream directly out of the configuration image through a read pointer.

Top module: `vcmd_engine`

## Requirements
- R1: After reset no command is in progress (busy=0), no reply is pending (data_ready=0), init_req=1, and lock, invalid_cmd, done_irq and mbx24_mode are all 0.
- R2: The number of parameter bytes depends on the opcode. 0x22 takes 35, 0x23 takes 3, 0x24 takes 1, 0x25 takes 4, 0x29 takes 2, 0x39 takes 3, 0x40 takes 2, and every other opcode takes none. The command executes on the clock edge after its last parameter byte (or after its opcode, when it has no parameters) is accepted. done_irq rises at that execution edge and clears when the next opcode is accepted.
- R3: Opcode 0x22 takes its parameters in this order: a don't-care byte, a length L, an offset O, then 32 data bytes. It stores data byte i at address (O+i) mod 256 for i < min(L,32), leaves every other address unchanged, and produces no reply.
- R4: Opcode 0x23 takes a don't-care byte, a length L and an offset O. It replies with L bytes read from addresses (O+i) mod 256. L=0 gives no reply.
- R5: Opcode 0x28 replies with two bytes: 0x08 first, then the lock flag in bit 0.
- R6: Opcode 0x29 takes parameters P0 and P1. If P1 equals the current lock value (0x00 or 0x01), the lock becomes bit 0 of P0. Otherwise the lock is left unchanged. No reply is produced, and the lock never changes outside such an execution.
- R7: Opcode 0x2C replies 0x40. Opcode 0x2D replies 0x00, 0x00. Opcode 0x40 replies 0xFF. Opcodes 0x39 and 0x24 accept their parameters and produce no reply.
- R8: Opcode 0x25 loads mbx_count from P0 and loads mbx_addr from P1..P3, most significant byte first. It also sets mbx24_mode and clears init_req. init_req never rises again before the next reset.
- R9: An opcode that is not in R2's list (e.g. 0x10, 0x26, 0xFF) sets invalid_cmd and produces no reply. invalid_cmd clears when the next opcode is accepted.
- R10: While data_ready=1, rd_data shows the current reply byte, and rd_req advances to the next byte. data_ready falls after the last byte is taken. rd_req with no pending reply is ignored.
- R11: An opcode byte written in the execution cycle, or while reply bytes are pending, is not accepted. It sets invalid_cmd and leaves the pending reply intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Opcode or parameter byte |
| rd_req | input | 1 | Take the current reply byte |
| rd_data | output | 8 | Current reply byte |
| data_ready | output | 1 | Reply bytes pending |
| busy | output | 1 | Parameter collection or execution in progress |
| invalid_cmd | output | 1 | Invalid-command status |
| done_irq | output | 1 | Command completed |
| init_req | output | 1 | Mailbox initialization still required |
| lock | output | 1 | Mailbox interface lock flag |
| mbx24_mode | output | 1 | 24-bit mailbox mode selected |
| mbx_count | output | 8 | Latched mailbox count |
| mbx_addr | output | 24 | Latched mailbox address |

## Verification
Two functions can land in the same cycle. A host pop can coincide with a write of a new opcode, and the final reply byte can be taken in the very edge where that opcode arrives. The bench provokes this by raising rd_req and cmd_wr together while exactly one reply byte is pending. It then judges the result: the pop must complete and clear data_ready, and the opcode must still be refused with invalid_cmd set. A following well-formed command must run normally and clear invalid_cmd. A second provocation writes an opcode in the execution cycle of a zero-parameter command and checks that the original reply survives.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
    localparam logic [7:0] OP_CFG_WR   = 8'h22;
    localparam logic [7:0] OP_CFG_RD   = 8'h23;
    localparam logic [7:0] OP_SHADOW   = 8'h24;
    localparam logic [7:0] OP_MBX_INIT = 8'h25;
    localparam logic [7:0] OP_EXT_INFO = 8'h28;
    localparam logic [7:0] OP_MBX_LOCK = 8'h29;
    localparam logic [7:0] OP_TERM     = 8'h2C;
    localparam logic [7:0] OP_PAIR     = 8'h2D;
    localparam logic [7:0] OP_POKE     = 8'h39;
    localparam logic [7:0] OP_PEEK     = 8'h40;

    localparam logic [7:0] EXT_INFO_TAG = 8'h08;
    localparam logic [7:0] TERM_STATUS  = 8'h40;
    localparam logic [7:0] PEEK_FILL    = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PARAM = 2'd1,
        ST_EXEC  = 2'd2
    } phase_e;
endpackage

// File: rtl/vcmd_plen.sv
module vcmd_plen
    import vcmd_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic [7:0]    op,
    output logic [PW-1:0] plen
);
    always_comb begin
        unique case (op)
            OP_CFG_WR:   plen = PW'(35);
            OP_CFG_RD:   plen = PW'(3);
            OP_SHADOW:   plen = PW'(1);
            OP_MBX_INIT: plen = PW'(4);
            OP_MBX_LOCK: plen = PW'(2);
            OP_POKE:     plen = PW'(3);
            OP_PEEK:     plen = PW'(2);
            default:     plen = '0;
        endcase
    end
endmodule

// File: rtl/vcmd_cfg_mem.sv
module vcmd_cfg_mem #(
    parameter int AW   = 8,
    parameter int WMAX = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_off,
    input  logic [$clog2(WMAX+1)-1:0] wr_len,
    input  logic [WMAX-1:0][7:0] wr_bytes,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = $clog2(WMAX);

    logic [DEPTH-1:0][7:0] image;

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        logic [AW-1:0] rel;
        logic          hit;
        logic [7:0]    cell_q;

        assign rel = AW'(e) - wr_off;
        assign hit = wr_en && (32'(rel) < 32'(wr_len));

        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (hit)
                cell_q <= wr_bytes[rel[IW-1:0]];
        end

        assign image[e] = cell_q;
    end

    assign rd_data = image[rd_addr];
endmodule

// File: rtl/vcmd_engine.sv
module vcmd_engine
    import vcmd_pkg::*;
#(
    parameter int CFG_AW = 8,
    parameter int WR_MAX = 32,
    parameter int HDR    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_data,
    input  logic        rd_req,
    output logic [7:0]  rd_data,
    output logic        data_ready,
    output logic        busy,
    output logic        invalid_cmd,
    output logic        done_irq,
    output logic        init_req,
    output logic        lock,
    output logic        mbx24_mode,
    output logic [7:0]  mbx_count,
    output logic [23:0] mbx_addr
);
    localparam int PMAX = HDR + WR_MAX;
    localparam int PIW  = $clog2(PMAX + 1);
    localparam int WLW  = $clog2(WR_MAX + 1);

    typedef struct packed {
        phase_e               ph;
        logic [7:0]           op;
        logic [PIW-1:0]       pidx;
        logic [PMAX-1:0][7:0] pbuf;
        logic [7:0]           rcnt;
        logic [7:0]           rptr;
        logic                 rsel;
        logic [1:0][7:0]      rfix;
        logic                 lock;
        logic                 inv;
        logic                 irq;
        logic                 initreq;
        logic                 mbx24;
        logic [7:0]           mcnt;
        logic [23:0]          maddr;
    } eng_t;

    eng_t q, d;

    logic [PIW-1:0]         new_len, cur_len;
    logic                   mem_wr;
    logic [WLW-1:0]         mem_len;
    logic [7:0]             mem_rd;
    logic [WR_MAX-1:0][7:0] mem_bytes;

    vcmd_plen #(.PW(PIW)) u_len_new (.op(cmd_data), .plen(new_len));
    vcmd_plen #(.PW(PIW)) u_len_cur (.op(q.op),     .plen(cur_len));

    assign mem_wr    = (q.ph == ST_EXEC) && (q.op == OP_CFG_WR);
    assign mem_len   = (q.pbuf[1] > 8'(WR_MAX)) ? WLW'(WR_MAX) : WLW'(q.pbuf[1]);
    assign mem_bytes = q.pbuf[PMAX-1:HDR];

    vcmd_cfg_mem #(.AW(CFG_AW), .WMAX(WR_MAX)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_wr),
        .wr_off   (CFG_AW'(q.pbuf[2])),
        .wr_len   (mem_len),
        .wr_bytes (mem_bytes),
        .rd_addr  (CFG_AW'(q.rptr)),
        .rd_data  (mem_rd)
    );

    always_comb begin
        d = q;
        if (rd_req && (q.rcnt != 8'd0)) begin
            d.rcnt = q.rcnt - 8'd1;
            d.rptr = q.rptr + 8'd1;
        end
        unique case (q.ph)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (q.rcnt != 8'd0) begin
                        d.inv = 1'b1;
                    end else begin
                        d.op   = cmd_data;
                        d.inv  = 1'b0;
                        d.irq  = 1'b0;
                        d.pidx = '0;
                        d.ph   = (new_len == '0) ? ST_EXEC : ST_PARAM;
                    end
                end
            end
            ST_PARAM: begin
                if (cmd_wr) begin
                    d.pbuf[q.pidx] = cmd_data;
                    d.pidx = q.pidx + PIW'(1);
                    if (d.pidx == cur_len)
                        d.ph = ST_EXEC;
                end
            end
            default: begin
                if (cmd_wr)
                    d.inv = 1'b1;
                d.ph   = ST_IDLE;
                d.irq  = 1'b1;
                d.rcnt = 8'd0;
                d.rptr = 8'd0;
                d.rsel = 1'b0;
                unique case (q.op)
                    OP_CFG_WR, OP_SHADOW, OP_POKE: ;
                    OP_CFG_RD: begin
                        d.rcnt = q.pbuf[1];
                        d.rptr = q.pbuf[2];
                        d.rsel = 1'b1;
                    end
                    OP_MBX_INIT: begin
                        d.mcnt    = q.pbuf[0];
                        d.maddr   = {q.pbuf[1], q.pbuf[2], q.pbuf[3]};
                        d.mbx24   = 1'b1;
                        d.initreq = 1'b0;
                    end
                    OP_EXT_INFO: begin
                        d.rcnt    = 8'd2;
                        d.rfix[0] = EXT_INFO_TAG;
                        d.rfix[1] = {7'd0, q.lock};
                    end
                    OP_MBX_LOCK: begin
                        if (q.pbuf[1] == {7'd0, q.lock})
                            d.lock = q.pbuf[0][0];
                    end
                    OP_TERM: begin
                        d.rcnt    = 8'd1;
                        d.rfix[0] = TERM_STATUS;
                    end
                    OP_PAIR: begin
                        d.rcnt = 8'd2;
                        d.rfix = '0;
                    end
                    OP_PEEK: begin
                        d.rcnt    = 8'd1;
                        d.rfix[0] = PEEK_FILL;
                    end
                    default: d.inv = 1'b1;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.ph      <= ST_IDLE;
            q.initreq <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_data     = q.rsel ? mem_rd : q.rfix[q.rptr[0]];
    assign data_ready  = (q.rcnt != 8'd0);
    assign busy        = (q.ph != ST_IDLE);
    assign invalid_cmd = q.inv;
    assign done_irq    = q.irq;
    assign init_req    = q.initreq;
    assign lock        = q.lock;
    assign mbx24_mode  = q.mbx24;
    assign mbx_count   = q.mcnt;
    assign mbx_addr    = q.maddr;

    // R10
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_req) |=> data_ready);
    // R10
    last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && q.rcnt == 8'd1) |=> !data_ready);
    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != ST_EXEC) |=> $stable(lock));
    // R8
    init_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_req |=> !init_req);
    // R11
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && data_ready && !busy) |=> invalid_cmd);
    // R2
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == ST_EXEC) |=> (done_irq && !busy));
endmodule

// File: tb/tb_vcmd_engine.sv
module tb_vcmd_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [7:0]  cmd_data;
    logic        rd_req;
    logic [7:0]  rd_data;
    logic        data_ready, busy, invalid_cmd, done_irq, init_req, lock, mbx24_mode;
    logic [7:0]  mbx_count;
    logic [23:0] mbx_addr;

    always #5 clk = ~clk;

    vcmd_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .rd_req(rd_req), .rd_data(rd_data), .data_ready(data_ready), .busy(busy),
        .invalid_cmd(invalid_cmd), .done_irq(done_irq), .init_req(init_req),
        .lock(lock), .mbx24_mode(mbx24_mode), .mbx_count(mbx_count), .mbx_addr(mbx_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0] bq [0:47];
    int bn;

    task automatic send_cmd();
        for (int i = 0; i < bn; i++) begin
            cmd_wr   = 1'b1;
            cmd_data = bq[i];
            @(negedge clk);
        end
        cmd_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop(output logic [7:0] b);
        b      = rd_data;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0] op;
        logic [1:0] np;
        logic [7:0] p0, p1, p2;
        logic [1:0] cnt;
        logic [7:0] b0, b1;
        logic       inv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VTBL [0:NV-1] = '{
        '{8'h2C, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1, 8'h40, 8'h00, 1'b0},
        '{8'h2D, 2'd0, 8'h00, 8'h00, 8'h00, 2'd2, 8'h00, 8'h00, 1'b0},
        '{8'h28, 2'd0, 8'h00, 8'h00, 8'h00, 2'd2, 8'h08, 8'h00, 1'b0},
        '{8'h40, 2'd2, 8'h12, 8'h34, 8'h00, 2'd1, 8'hFF, 8'h00, 1'b0},
        '{8'h39, 2'd3, 8'h01, 8'h02, 8'h03, 2'd0, 8'h00, 8'h00, 1'b0},
        '{8'h24, 2'd1, 8'h03, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b0},
        '{8'h10, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b1},
        '{8'hFF, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b1},
        '{8'h26, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b1}
    };

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] b;
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_data = '0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 data_ready", data_ready, 0);
        chk("R1 init_req", init_req, 1);
        chk("R1 lock", lock, 0);
        chk("R1 invalid", invalid_cmd, 0);
        chk("R1 done_irq", done_irq, 0);
        chk("R1 mbx24", mbx24_mode, 0);

        // R2 R5 R7 R9 R10 vector table
        for (int v = 0; v < NV; v++) begin
            bq[0] = VTBL[v].op; bq[1] = VTBL[v].p0; bq[2] = VTBL[v].p1; bq[3] = VTBL[v].p2;
            bn = 1 + int'(VTBL[v].np);
            send_cmd();
            chk("R2 done_irq", done_irq, 1);
            chk("R9 invalid", invalid_cmd, VTBL[v].inv);
            chk("R7 reply pending", data_ready, (VTBL[v].cnt != 0));
            if (VTBL[v].cnt >= 1) begin pop(b); chk("R7 byte0", b, VTBL[v].b0); end
            if (VTBL[v].cnt >= 2) begin pop(b); chk("R5 byte1", b, VTBL[v].b1); end
            chk("R10 drained", data_ready, 0);
        end

        // R2 parameter count and execution timing
        cmd_wr = 1'b1; cmd_data = 8'h40; @(negedge clk);
        cmd_data = 8'h12; @(negedge clk);
        cmd_wr = 1'b0; @(negedge clk);
        chk("R2 waiting busy", busy, 1);
        chk("R2 irq cleared", done_irq, 0);
        chk("R2 no early reply", data_ready, 0);
        cmd_wr = 1'b1; cmd_data = 8'h34; @(negedge clk);
        cmd_wr = 1'b0;
        chk("R2 exec pending irq", done_irq, 0);
        @(negedge clk);
        chk("R2 executed irq", done_irq, 1);
        chk("R2 busy clear", busy, 0);
        pop(b);
        chk("R7 peek byte", b, 8'hFF);

        // R6 lock handshake
        bq[0] = 8'h29; bq[1] = 8'h01; bq[2] = 8'h01; bn = 3; send_cmd();
        chk("R6 mismatch keeps", lock, 0);
        bq[2] = 8'h00; send_cmd();
        chk("R6 set lock", lock, 1);
        chk("R6 no reply", data_ready, 0);
        bq[0] = 8'h28; bn = 1; send_cmd();
        pop(b); chk("R5 tag", b, 8'h08);
        pop(b); chk("R5 lock byte", b, 8'h01);
        bq[0] = 8'h29; bq[1] = 8'h00; bq[2] = 8'h00; bn = 3; send_cmd();
        chk("R6 mismatch keeps set", lock, 1);
        bq[2] = 8'h01; send_cmd();
        chk("R6 clear lock", lock, 0);

        // R8 mailbox init
        bq[0] = 8'h25; bq[1] = 8'h05; bq[2] = 8'h12; bq[3] = 8'h34; bq[4] = 8'h56; bn = 5;
        send_cmd();
        chk("R8 count", mbx_count, 8'h05);
        chk("R8 addr", mbx_addr, 24'h123456);
        chk("R8 mode", mbx24_mode, 1);
        chk("R8 init_req", init_req, 0);
        chk("R8 no reply", data_ready, 0);

        // R3 R4 wrapped write then read
        bq[0] = 8'h22; bq[1] = 8'h00; bq[2] = 8'h04; bq[3] = 8'hFE;
        for (int j = 0; j < 32; j++) bq[4+j] = (j < 4) ? 8'(8'hA0 + j) : 8'h00;
        bn = 36; send_cmd();
        chk("R3 no reply", data_ready, 0);
        chk("R3 valid", invalid_cmd, 0);
        bq[0] = 8'h23; bq[1] = 8'h00; bq[2] = 8'h05; bq[3] = 8'hFD; bn = 4; send_cmd();
        pop(b); chk("R4 untouched FD", b, 8'h00);
        for (int j = 0; j < 4; j++) begin
            pop(b); chk("R4 wrap byte", b, 8'(8'hA0 + j));
        end
        chk("R4 drained", data_ready, 0);

        // R3 length clamp to 32
        bq[0] = 8'h22; bq[1] = 8'h00; bq[2] = 8'h28; bq[3] = 8'h10;
        for (int j = 0; j < 32; j++) bq[4+j] = 8'(8'h40 + j);
        bn = 36; send_cmd();
        bq[0] = 8'h23; bq[1] = 8'h00; bq[2] = 8'h21; bq[3] = 8'h10; bn = 4; send_cmd();
        for (int j = 0; j < 32; j++) begin
            pop(b); chk("R3 clamp data", b, 8'(8'h40 + j));
        end
        pop(b); chk("R3 beyond clamp", b, 8'h00);

        // R4 zero length
        bq[0] = 8'h23; bq[1] = 8'h00; bq[2] = 8'h00; bq[3] = 8'h10; bn = 4; send_cmd();
        chk("R4 len0 no reply", data_ready, 0);
        chk("R4 len0 done", done_irq, 1);

        // R11 opcode while reply pending
        bq[0] = 8'h2D; bn = 1; send_cmd();
        cmd_wr = 1'b1; cmd_data = 8'h2C; @(negedge clk);
        cmd_wr = 1'b0;
        chk("R11 invalid", invalid_cmd, 1);
        chk("R11 reply kept", data_ready, 1);
        pop(b); chk("R11 byte0", b, 8'h00);
        pop(b); chk("R11 byte1", b, 8'h00);
        chk("R11 drained", data_ready, 0);

        // R11 R10 pop and opcode in the same cycle
        bq[0] = 8'h2C; bn = 1; send_cmd();
        chk("R10 current byte", rd_data, 8'h40);
        rd_req = 1'b1; cmd_wr = 1'b1; cmd_data = 8'h28; @(negedge clk);
        rd_req = 1'b0; cmd_wr = 1'b0;
        chk("R10 popped", data_ready, 0);
        chk("R11 same-cycle reject", invalid_cmd, 1);
        chk("R11 not started", busy, 0);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk("R10 empty pop ignored", data_ready, 0);
        bq[0] = 8'h2D; bn = 1; send_cmd();
        chk("R9 invalid cleared", invalid_cmd, 0);
        pop(b); pop(b);
        chk("R10 no underflow", data_ready, 0);

        // R11 opcode in execution cycle
        cmd_wr = 1'b1; cmd_data = 8'h2C; @(negedge clk);
        cmd_data = 8'h2D; @(negedge clk);
        cmd_wr = 1'b0;
        chk("R11 exec reject", invalid_cmd, 1);
        pop(b); chk("R11 exec reply", b, 8'h40);
        chk("R11 single byte", data_ready, 0);

        finish_run();
    end
endmodule